// File: doc/BRIEF.md
# Per-Port Frame Statistics Counters

This block holds the traffic statistics of one switch port. The MAC raises a single-cycle event at the end of every frame it receives or sends. The event carries the frame length and direction, the destination class, and four flags: checksum error, alignment error, pause and drop. From that event the block decodes which counters to bump. These are packet counts per class, octet totals, error counts per kind, and a six-bucket length histogram for each direction.

Software reads the counters through a 32-bit read port that spans a 0x400-byte window. The window has one counter per 0x10-byte slot. A synchronous clear input zeroes every counter at once. Octet totals and the receive discard count are 64 bits wide, with the low word at the slot base and the high word at base+4. All other counters are 32 bits wide, and every counter wraps at its width.

Top module: `port_stat_counters`

## Requirements
- R1: After rst_ni is asserted and released, every counter reads as zero.
- R2: Read data appears on rd_data_o one clock after rd_addr_i is presented, and it reflects the counters as they were at that edge. Only address bits [9:2] are decoded. An offset holding no counter word reads zero. This includes the slot after a 64-bit counter, and offsets with bit 3 set.
- R3: Transmit octets (0x000) and receive octets (0x140) are 64-bit counters, with the low word at the base and the high word at base+4. Receive octets grows by the length of every receive frame. Transmit octets grows by the length of every non-dropped transmit frame. A transmit frame never changes a receive counter.
- R4: On transmit, a dropped frame only increments the drop counter (0x020). A non-dropped pause frame increments the pause counter (0x030). Any other non-dropped frame increments unicast (0x040), multicast (0x050) or broadcast (0x060), for class codes 0, 1 and 2. Class code 3 increments no class counter. The error flags have no effect on transmit. With ev_valid_i low, no counter changes.
- R5: A receive frame is good when it has no checksum error, no alignment error and no drop. A good frame adds its length to good octets (0x220). A good pause frame increments receive pause (0x170). A good non-pause frame increments unicast (0x260), multicast (0x270) or broadcast (0x280), using the same class codes as transmit.
- R6: Both directions have a histogram with six buckets: exactly 64, 65-127, 128-255, 256-511, 512-1023 and 1024 to 1518. The transmit buckets sit at 0x070-0x0C0 and the receive buckets at 0x180-0x1D0. Receive frames in range are always counted. Transmit frames are counted unless dropped. Frames outside 64..1518 enter no bucket.
- R7: A receive frame below 64 bytes counts as a fragment (0x290) if it has a checksum error, and as undersize (0x160) otherwise. A receive frame above 1518 bytes counts as jabber (0x1F0) if it has a checksum error, and as oversize (0x1E0) otherwise.
- R8: A receive checksum error increments 0x210 and an alignment error increments 0x200. Neither kind of frame adds good octets or increments a class counter.
- R9: A dropped receive frame increments the 64-bit discard counter at 0x240. It still adds its length to receive octets, but it is not a good frame.
- R10: With clr_i high, every counter becomes zero at the next edge. Any frame event in that same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of all counters |
| ev_valid_i | input | 1 | Frame-end event strobe |
| ev_tx_i | input | 1 | 1 = transmit frame, 0 = receive frame |
| ev_len_i | input | 14 | Frame length in bytes |
| ev_cls_i | input | 2 | Destination class: 0 unicast, 1 multicast, 2 broadcast |
| ev_fcs_err_i | input | 1 | Frame check sequence error |
| ev_align_err_i | input | 1 | Alignment error (receive only) |
| ev_pause_i | input | 1 | Pause frame |
| ev_drop_i | input | 1 | Frame dropped |
| rd_addr_i | input | 10 | Byte offset within the counter window |
| rd_data_o | output | 32 | Registered read data |

## Verification
The hardest cases are the ones where a frame must leave a counter untouched. For example, a checksum-error frame must not add good octets, and a dropped transmit frame must not enter the histogram. Such a check only means something if the counter started from a known value. So each table vector first pulses clr_i, then sends one frame, then reads one offset, and the untouched counters are read back as zero. The clear that coincides with an event is reached by raising clr_i and ev_valid_i on the same falling edge. The one-cycle read latency is checked by changing the address and sampling both before and after the next rising edge.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int NUM_CNT = 31;
  localparam int ADDR_W  = 10;
  localparam int HIST_N  = 6;

  // counter ids
  localparam int CI_TX_OCT   = 0;
  localparam int CI_TX_DROP  = 1;
  localparam int CI_TX_PAUSE = 2;
  localparam int CI_TX_UC    = 3;
  localparam int CI_TX_MC    = 4;
  localparam int CI_TX_BC    = 5;
  localparam int CI_TX_H0    = 6;
  localparam int CI_RX_OCT   = 12;
  localparam int CI_RX_UNDER = 13;
  localparam int CI_RX_PAUSE = 14;
  localparam int CI_RX_H0    = 15;
  localparam int CI_RX_OVER  = 21;
  localparam int CI_RX_JAB   = 22;
  localparam int CI_RX_ALIGN = 23;
  localparam int CI_RX_FCS   = 24;
  localparam int CI_RX_GOOD  = 25;
  localparam int CI_RX_DISC  = 26;
  localparam int CI_RX_UC    = 27;
  localparam int CI_RX_MC    = 28;
  localparam int CI_RX_BC    = 29;
  localparam int CI_RX_FRAG  = 30;

  // 0x10-byte slot of each counter id
  localparam logic [5:0] SLOT_OF [NUM_CNT] = '{
    6'd0, 6'd2, 6'd3, 6'd4, 6'd5, 6'd6, 6'd7, 6'd8, 6'd9, 6'd10, 6'd11, 6'd12,
    6'd20, 6'd22, 6'd23, 6'd24, 6'd25, 6'd26, 6'd27, 6'd28, 6'd29, 6'd30,
    6'd31, 6'd32, 6'd33, 6'd34, 6'd36, 6'd38, 6'd39, 6'd40, 6'd41};

  localparam logic [NUM_CNT-1:0] WIDE_MASK =
    (NUM_CNT'(1) << CI_TX_OCT) | (NUM_CNT'(1) << CI_RX_OCT) |
    (NUM_CNT'(1) << CI_RX_GOOD) | (NUM_CNT'(1) << CI_RX_DISC);

  localparam logic [NUM_CNT-1:0] OCTET_MASK =
    (NUM_CNT'(1) << CI_TX_OCT) | (NUM_CNT'(1) << CI_RX_OCT) |
    (NUM_CNT'(1) << CI_RX_GOOD);

  typedef enum logic [1:0] {
    CLS_UC  = 2'd0,
    CLS_MC  = 2'd1,
    CLS_BC  = 2'd2,
    CLS_RSV = 2'd3
  } dst_cls_e;
endpackage

// File: rtl/stat_event_decode.sv
module stat_event_decode
  import stat_pkg::*;
#(
  parameter int LEN_W   = 14,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1518
) (
  input  logic               valid_i,
  input  logic               clr_i,
  input  logic               tx_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [1:0]         cls_i,
  input  logic               fcs_i,
  input  logic               align_i,
  input  logic               pause_i,
  input  logic               drop_i,
  output logic [NUM_CNT-1:0] inc_o
);
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);
  localparam logic [LEN_W-1:0] B2_L  = LEN_W'(128);
  localparam logic [LEN_W-1:0] B3_L  = LEN_W'(256);
  localparam logic [LEN_W-1:0] B4_L  = LEN_W'(512);
  localparam logic [LEN_W-1:0] B5_L  = LEN_W'(1024);

  logic              hit, is_short, is_long, good;
  logic [HIST_N-1:0] hist;
  dst_cls_e          cls;

  assign hit      = valid_i && !clr_i;
  assign is_short = len_i < MIN_L;
  assign is_long  = len_i > MAX_L;
  assign good     = !fcs_i && !align_i && !drop_i;
  assign cls      = dst_cls_e'(cls_i);

  always_comb begin
    hist = '0;
    if (!is_short && !is_long) begin
      if (len_i == MIN_L)    hist[0] = 1'b1;
      else if (len_i < B2_L) hist[1] = 1'b1;
      else if (len_i < B3_L) hist[2] = 1'b1;
      else if (len_i < B4_L) hist[3] = 1'b1;
      else if (len_i < B5_L) hist[4] = 1'b1;
      else                   hist[5] = 1'b1;
    end
  end

  always_comb begin
    inc_o = '0;
    if (hit && tx_i) begin
      if (drop_i) inc_o[CI_TX_DROP] = 1'b1;
      else begin
        inc_o[CI_TX_OCT] = 1'b1;
        inc_o[CI_TX_H0 +: HIST_N] = hist;
        if (pause_i) inc_o[CI_TX_PAUSE] = 1'b1;
        else begin
          case (cls)
            CLS_UC:  inc_o[CI_TX_UC] = 1'b1;
            CLS_MC:  inc_o[CI_TX_MC] = 1'b1;
            CLS_BC:  inc_o[CI_TX_BC] = 1'b1;
            default: ;
          endcase
        end
      end
    end else if (hit) begin
      inc_o[CI_RX_OCT] = 1'b1;
      inc_o[CI_RX_H0 +: HIST_N] = hist;
      if (drop_i)  inc_o[CI_RX_DISC]  = 1'b1;
      if (fcs_i)   inc_o[CI_RX_FCS]   = 1'b1;
      if (align_i) inc_o[CI_RX_ALIGN] = 1'b1;
      if (is_short) begin
        if (fcs_i) inc_o[CI_RX_FRAG]  = 1'b1;
        else       inc_o[CI_RX_UNDER] = 1'b1;
      end
      if (is_long) begin
        if (fcs_i) inc_o[CI_RX_JAB]  = 1'b1;
        else       inc_o[CI_RX_OVER] = 1'b1;
      end
      if (good) begin
        inc_o[CI_RX_GOOD] = 1'b1;
        if (pause_i) inc_o[CI_RX_PAUSE] = 1'b1;
        else begin
          case (cls)
            CLS_UC:  inc_o[CI_RX_UC] = 1'b1;
            CLS_MC:  inc_o[CI_RX_MC] = 1'b1;
            CLS_BC:  inc_o[CI_RX_BC] = 1'b1;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/stat_counter.sv
module stat_counter #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [WIDTH-1:0] amt_i,
  output logic [WIDTH-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + amt_i; // wraps modulo 2**WIDTH
  end
endmodule

// File: rtl/stat_read_mux.sv
module stat_read_mux
  import stat_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  word_addr_i,
  input  logic [63:0] cnt_i [NUM_CNT],
  output logic [31:0] rd_data_o
);
  logic [5:0]  slot;
  logic [1:0]  sub;
  logic [31:0] word;

  assign slot = word_addr_i[7:2];
  assign sub  = word_addr_i[1:0];

  always_comb begin
    word = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (slot == SLOT_OF[i]) begin
        if (sub == 2'd0)                    word = cnt_i[i][31:0];
        else if (sub == 2'd1 && WIDE_MASK[i]) word = cnt_i[i][63:32];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= '0;
    else         rd_data_o <= word;
  end
endmodule

// File: rtl/port_stat_counters.sv
module port_stat_counters
  import stat_pkg::*;
#(
  parameter int LEN_W   = 14,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1518
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              ev_valid_i,
  input  logic              ev_tx_i,
  input  logic [LEN_W-1:0]  ev_len_i,
  input  logic [1:0]        ev_cls_i,
  input  logic              ev_fcs_err_i,
  input  logic              ev_align_err_i,
  input  logic              ev_pause_i,
  input  logic              ev_drop_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [31:0]       rd_data_o
);
  logic [NUM_CNT-1:0] inc;
  logic [63:0]        cnt_val [NUM_CNT];
  logic               unused_byte_lane;

  assign unused_byte_lane = ^rd_addr_i[1:0];

  stat_event_decode #(
    .LEN_W  (LEN_W),
    .MIN_LEN(MIN_LEN),
    .MAX_LEN(MAX_LEN)
  ) u_decode (
    .valid_i(ev_valid_i),
    .clr_i  (clr_i),
    .tx_i   (ev_tx_i),
    .len_i  (ev_len_i),
    .cls_i  (ev_cls_i),
    .fcs_i  (ev_fcs_err_i),
    .align_i(ev_align_err_i),
    .pause_i(ev_pause_i),
    .drop_i (ev_drop_i),
    .inc_o  (inc)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    localparam int W = WIDE_MASK[g] ? 64 : 32;
    logic [W-1:0] amt, val;
    assign amt = OCTET_MASK[g] ? W'(ev_len_i) : W'(1);

    stat_counter #(.WIDTH(W)) u_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (clr_i),
      .inc_i (inc[g]),
      .amt_i (amt),
      .cnt_o (val)
    );
    assign cnt_val[g] = 64'(val);
  end

  stat_read_mux u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .word_addr_i(rd_addr_i[ADDR_W-1:2]),
    .cnt_i      (cnt_val),
    .rd_data_o  (rd_data_o)
  );
endmodule

// File: rtl/port_stat_counters_chk.sv
module port_stat_counters_chk
  import stat_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        clr_i,
  input logic        ev_valid_i,
  input logic        ev_tx_i,
  input logic        ev_fcs_err_i,
  input logic [7:0]  slot_i,
  input logic [31:0] rd_data_o,
  input logic [63:0] cnt_i [NUM_CNT]
);
  logic [NUM_CNT*64-1:0] flat;
  logic                  unmapped;

  always_comb begin
    for (int i = 0; i < NUM_CNT; i++) flat[i*64 +: 64] = cnt_i[i];
  end

  assign unmapped = (slot_i[7:2] > 6'd41) ||
                    (slot_i[7:2] > 6'd12 && slot_i[7:2] < 6'd20) || slot_i[1];

  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_i, 2) |-> rd_data_o == 32'd0); // R10

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(unmapped) |-> rd_data_o == 32'd0); // R2

  AST_RD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(slot_i) == slot_i && !$past(ev_valid_i) && !$past(clr_i))
      |=> $stable(rd_data_o)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(ev_valid_i) && !$past(clr_i)) |-> flat == $past(flat)); // R4

  AST_FCS_NO_GOOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && !clr_i && !ev_tx_i && ev_fcs_err_i)
      |=> $stable(cnt_i[CI_RX_GOOD])); // R8

  AST_TX_NO_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && !clr_i && ev_tx_i) |=> $stable(cnt_i[CI_RX_OCT])); // R3
endmodule

bind port_stat_counters port_stat_counters_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clr_i       (clr_i),
  .ev_valid_i  (ev_valid_i),
  .ev_tx_i     (ev_tx_i),
  .ev_fcs_err_i(ev_fcs_err_i),
  .slot_i      (rd_addr_i[9:2]),
  .rd_data_o   (rd_data_o),
  .cnt_i       (cnt_val)
);

// File: tb/port_stat_counters_bench.sv
module port_stat_counters_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 50000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clr_i = 1'b0;
  logic        ev_valid_i = 1'b0;
  logic        ev_tx_i = 1'b0;
  logic [13:0] ev_len_i = '0;
  logic [1:0]  ev_cls_i = '0;
  logic        ev_fcs_err_i = 1'b0;
  logic        ev_align_err_i = 1'b0;
  logic        ev_pause_i = 1'b0;
  logic        ev_drop_i = 1'b0;
  logic [9:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;

  port_stat_counters u_port_stat_counters (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .clr_i         (clr_i),
    .ev_valid_i    (ev_valid_i),
    .ev_tx_i       (ev_tx_i),
    .ev_len_i      (ev_len_i),
    .ev_cls_i      (ev_cls_i),
    .ev_fcs_err_i  (ev_fcs_err_i),
    .ev_align_err_i(ev_align_err_i),
    .ev_pause_i    (ev_pause_i),
    .ev_drop_i     (ev_drop_i),
    .rd_addr_i     (rd_addr_i),
    .rd_data_o     (rd_data_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int failures = 0;

  // flg = {fcs, align, pause, drop}
  typedef struct packed {
    logic        tx;
    logic [13:0] len;
    logic [1:0]  cls;
    logic [3:0]  flg;
    logic [9:0]  off;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 49;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 14'd100,  2'd0, 4'b0000, 10'h000, 32'd100, 8'd3},  // R3
    '{1'b1, 14'd100,  2'd0, 4'b0000, 10'h040, 32'd1,   8'd4},  // R4
    '{1'b1, 14'd100,  2'd1, 4'b0000, 10'h050, 32'd1,   8'd4},  // R4
    '{1'b1, 14'd100,  2'd2, 4'b0000, 10'h060, 32'd1,   8'd4},  // R4
    '{1'b1, 14'd100,  2'd3, 4'b0000, 10'h040, 32'd0,   8'd4},  // R4
    '{1'b1, 14'd100,  2'd0, 4'b0001, 10'h020, 32'd1,   8'd4},  // R4
    '{1'b1, 14'd100,  2'd0, 4'b0001, 10'h000, 32'd0,   8'd4},  // R4
    '{1'b1, 14'd100,  2'd0, 4'b0001, 10'h080, 32'd0,   8'd6},  // R6
    '{1'b1, 14'd64,   2'd0, 4'b0010, 10'h030, 32'd1,   8'd4},  // R4
    '{1'b1, 14'd64,   2'd0, 4'b0010, 10'h040, 32'd0,   8'd4},  // R4
    '{1'b1, 14'd100,  2'd0, 4'b1100, 10'h040, 32'd1,   8'd4},  // R4
    '{1'b1, 14'd64,   2'd0, 4'b0000, 10'h070, 32'd1,   8'd6},  // R6
    '{1'b1, 14'd127,  2'd0, 4'b0000, 10'h080, 32'd1,   8'd6},  // R6
    '{1'b1, 14'd128,  2'd0, 4'b0000, 10'h090, 32'd1,   8'd6},  // R6
    '{1'b1, 14'd511,  2'd0, 4'b0000, 10'h0A0, 32'd1,   8'd6},  // R6
    '{1'b1, 14'd1023, 2'd0, 4'b0000, 10'h0B0, 32'd1,   8'd6},  // R6
    '{1'b1, 14'd1024, 2'd0, 4'b0000, 10'h0C0, 32'd1,   8'd6},  // R6
    '{1'b1, 14'd63,   2'd0, 4'b0000, 10'h070, 32'd0,   8'd6},  // R6
    '{1'b0, 14'd65,   2'd0, 4'b0000, 10'h180, 32'd0,   8'd6},  // R6
    '{1'b0, 14'd65,   2'd0, 4'b0000, 10'h190, 32'd1,   8'd6},  // R6
    '{1'b0, 14'd1518, 2'd0, 4'b0000, 10'h1D0, 32'd1,   8'd6},  // R6
    '{1'b0, 14'd1519, 2'd0, 4'b0000, 10'h1D0, 32'd0,   8'd6},  // R6
    '{1'b0, 14'd1519, 2'd0, 4'b0000, 10'h1E0, 32'd1,   8'd7},  // R7
    '{1'b0, 14'd1519, 2'd0, 4'b1000, 10'h1F0, 32'd1,   8'd7},  // R7
    '{1'b0, 14'd1519, 2'd0, 4'b1000, 10'h1E0, 32'd0,   8'd7},  // R7
    '{1'b0, 14'd63,   2'd0, 4'b0000, 10'h160, 32'd1,   8'd7},  // R7
    '{1'b0, 14'd63,   2'd0, 4'b1000, 10'h290, 32'd1,   8'd7},  // R7
    '{1'b0, 14'd63,   2'd0, 4'b1000, 10'h160, 32'd0,   8'd7},  // R7
    '{1'b0, 14'd200,  2'd0, 4'b1000, 10'h210, 32'd1,   8'd8},  // R8
    '{1'b0, 14'd200,  2'd0, 4'b1000, 10'h220, 32'd0,   8'd8},  // R8
    '{1'b0, 14'd200,  2'd0, 4'b1000, 10'h260, 32'd0,   8'd8},  // R8
    '{1'b0, 14'd200,  2'd0, 4'b1000, 10'h140, 32'd200, 8'd3},  // R3
    '{1'b0, 14'd200,  2'd0, 4'b0000, 10'h220, 32'd200, 8'd5},  // R5
    '{1'b0, 14'd200,  2'd0, 4'b0000, 10'h260, 32'd1,   8'd5},  // R5
    '{1'b0, 14'd200,  2'd1, 4'b0000, 10'h270, 32'd1,   8'd5},  // R5
    '{1'b0, 14'd200,  2'd2, 4'b0000, 10'h280, 32'd1,   8'd5},  // R5
    '{1'b0, 14'd200,  2'd0, 4'b0010, 10'h170, 32'd1,   8'd5},  // R5
    '{1'b0, 14'd200,  2'd0, 4'b0010, 10'h260, 32'd0,   8'd5},  // R5
    '{1'b0, 14'd200,  2'd0, 4'b0100, 10'h200, 32'd1,   8'd8},  // R8
    '{1'b0, 14'd200,  2'd0, 4'b0100, 10'h220, 32'd0,   8'd8},  // R8
    '{1'b0, 14'd200,  2'd0, 4'b0001, 10'h240, 32'd1,   8'd9},  // R9
    '{1'b0, 14'd200,  2'd0, 4'b0001, 10'h220, 32'd0,   8'd9},  // R9
    '{1'b0, 14'd200,  2'd0, 4'b0001, 10'h140, 32'd200, 8'd9},  // R9
    '{1'b0, 14'd200,  2'd0, 4'b0001, 10'h260, 32'd0,   8'd9},  // R9
    '{1'b1, 14'd100,  2'd0, 4'b0000, 10'h140, 32'd0,   8'd3},  // R3
    '{1'b1, 14'd100,  2'd0, 4'b0000, 10'h004, 32'd0,   8'd3},  // R3
    '{1'b1, 14'd100,  2'd0, 4'b0000, 10'h010, 32'd0,   8'd2},  // R2
    '{1'b1, 14'd100,  2'd0, 4'b0000, 10'h008, 32'd0,   8'd2},  // R2
    '{1'b0, 14'd200,  2'd0, 4'b0000, 10'h3F0, 32'd0,   8'd2}   // R2
  };

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic tx, input logic [13:0] len, input logic [1:0] cls,
                      input logic [3:0] flg);
    @(negedge clk);
    ev_valid_i = 1'b1;
    ev_tx_i = tx;
    ev_len_i = len;
    ev_cls_i = cls;
    {ev_fcs_err_i, ev_align_err_i, ev_pause_i, ev_drop_i} = flg;
    @(negedge clk);
    ev_valid_i = 1'b0;
    ev_tx_i = 1'b0;
    ev_len_i = '0;
    ev_cls_i = '0;
    {ev_fcs_err_i, ev_align_err_i, ev_pause_i, ev_drop_i} = 4'b0000;
  endtask

  task automatic rd(input logic [9:0] off, output logic [31:0] val);
    @(negedge clk);
    rd_addr_i = off;
    @(negedge clk);
    val = rd_data_o;
  endtask

  task automatic do_clr();
    @(negedge clk);
    clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R1 watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1: reset state
    rd(10'h000, v); chk(1, v, 32'd0);
    rd(10'h140, v); chk(1, v, 32'd0);
    rd(10'h290, v); chk(1, v, 32'd0);

    for (int i = 0; i < NV; i++) begin
      do_clr();
      send(VECS[i].tx, VECS[i].len, VECS[i].cls, VECS[i].flg);
      rd(VECS[i].off, v);
      chk(int'(VECS[i].req), v, VECS[i].exp);
    end

    // R3: accumulation across frames
    do_clr();
    for (int k = 0; k < 3; k++) send(1'b1, 14'd500, 2'd0, 4'b0000);
    rd(10'h000, v); chk(3, v, 32'd1500);
    rd(10'h004, v); chk(3, v, 32'd0);

    // R4: fields without ev_valid_i have no effect
    @(negedge clk);
    ev_tx_i = 1'b1; ev_len_i = 14'd100;
    @(negedge clk);
    ev_tx_i = 1'b0; ev_len_i = '0;
    rd(10'h000, v); chk(4, v, 32'd1500);
    rd(10'h040, v); chk(4, v, 32'd3);

    // R10: event coinciding with clear is discarded
    @(negedge clk);
    clr_i = 1'b1; ev_valid_i = 1'b1; ev_tx_i = 1'b1; ev_len_i = 14'd100;
    @(negedge clk);
    clr_i = 1'b0; ev_valid_i = 1'b0; ev_tx_i = 1'b0; ev_len_i = '0;
    rd(10'h000, v); chk(10, v, 32'd0);
    rd(10'h080, v); chk(10, v, 32'd0);

    // R2: one-cycle read latency
    send(1'b0, 14'd200, 2'd0, 4'b0000);
    send(1'b1, 14'd100, 2'd0, 4'b0000);
    rd(10'h000, v); chk(2, v, 32'd100);
    @(negedge clk);
    rd_addr_i = 10'h140;
    #1;
    chk(2, rd_data_o, 32'd100);
    @(negedge clk);
    chk(2, rd_data_o, 32'd200);

    // R9: discard counter high word
    send(1'b0, 14'd300, 2'd0, 4'b0001);
    rd(10'h244, v); chk(9, v, 32'd0);
    rd(10'h240, v); chk(9, v, 32'd1);

    // R1: asynchronous reset mid-run
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    rd(10'h140, v); chk(1, v, 32'd0);
    rd(10'h240, v); chk(1, v, 32'd0);

    finish_run();
  end
endmodule